// File: doc/BRIEF.md
# Inertial-Sensor FIFO Packet Stream Parser

This block sits behind the readout path of an inertial sensor's sample FIFO. It takes the raw bytes of one FIFO read, one byte per valid cycle, and cuts them into packets whose length is set by the first byte of each packet. For every complete packet it raises a one-cycle strobe. With the strobe it presents the accelerometer and gyroscope words, the temperature byte, the timestamp when the packet carries one, and the two rate-change flags.

A read begins with a start pulse that carries the number of packets waiting in the FIFO and an optional cap on how many to take. Three counters are cleared at that pulse: packets decoded, valid accelerometer samples and valid gyroscope samples. The read ends with a one-cycle done pulse. This happens when the packet budget is used up, or at once on a header the block cannot decode. Bytes that arrive outside a read are dropped.

Top module: `imu_stream_parser`

## Requirements
- R1: After reset `busy`, `rd_done`, `pkt_vld` and both rate flags are 0, and all three counters are 0.
- R2: A cycle with `rd_start` high clears the counters and loads a packet budget. The budget is `rd_pkt_limit` when that value is nonzero and smaller than `rd_pkt_count`, and `rd_pkt_count` otherwise. With a nonzero budget, `busy` is 1 in the next cycle.
- R3: A zero budget gives no packet strobe and no busy cycle. `rd_done` is 1 in the cycle after the start.
- R4: A header with bit 6 (accelerometer) and bit 5 (gyroscope) both set opens a 16-byte packet laid out as: header; accel X, Y, Z; gyro X, Y, Z; temperature; timestamp. Every word is little-endian. `pkt_vld` is 1 in the cycle after the 16th byte, with `pkt_ts_vld` = 1.
- R5: A header with exactly one of bits 6 and 5 set opens an 8-byte packet laid out as: header, X, Y, Z words of that sensor, temperature. The absent sensor's words and the timestamp read 0, and `pkt_ts_vld` = 0.
- R6: A header byte with bit 7 set ends the read. `rd_done` is 1 in the next cycle, no packet strobe is raised, and the counters keep their values.
- R7: A header byte with bit 7 clear and bits 6 and 5 both clear also ends the read, in the same way as R6.
- R8: Header bit 1 is reported on `pkt_odr_acc` and header bit 0 on `pkt_odr_gyr`, only in the cycle where `pkt_vld` is 1. Both are 0 in every other cycle.
- R9: `cnt_tot` rises by 1 for each packet. `cnt_acc` or `cnt_gyr` rises only when that sensor is present and its X word is not 16'h8000. The new counts are visible in the `pkt_vld` cycle.
- R10: When the budget is used up, `rd_done` is 1 in the same cycle as the last `pkt_vld`, and `busy` is 0 from then on. Later bytes change neither outputs nor counters until the next start.
- R11: Cycles with `in_vld` low neither advance nor disturb a packet. Header bits 4 to 2 do not change the packet length.
- R12: A start during a read drops any partly received packet and begins a new read under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_start | input | 1 | Begin a new read (one cycle) |
| rd_pkt_count | input | CNT_W | Packets available in the FIFO, sampled with `rd_start` |
| rd_pkt_limit | input | CNT_W | Cap on packets to take, 0 for no cap |
| in_vld | input | 1 | `in_byte` holds a stream byte |
| in_byte | input | 8 | Stream byte |
| busy | output | 1 | A read is in progress |
| rd_done | output | 1 | One-cycle end-of-read pulse |
| pkt_vld | output | 1 | One-cycle packet strobe |
| pkt_acc | output | 1 | Packet carried accelerometer data |
| pkt_gyr | output | 1 | Packet carried gyroscope data |
| acc_x | output | 16 | Accelerometer X |
| acc_y | output | 16 | Accelerometer Y |
| acc_z | output | 16 | Accelerometer Z |
| gyr_x | output | 16 | Gyroscope X |
| gyr_y | output | 16 | Gyroscope Y |
| gyr_z | output | 16 | Gyroscope Z |
| pkt_temp | output | 8 | Signed temperature byte |
| pkt_ts_vld | output | 1 | `pkt_ts` is meaningful |
| pkt_ts | output | 16 | Packet timestamp |
| pkt_odr_acc | output | 1 | Accelerometer rate-change flag, strobe |
| pkt_odr_gyr | output | 1 | Gyroscope rate-change flag, strobe |
| cnt_acc | output | CNT_W | Valid accelerometer samples in this read |
| cnt_gyr | output | CNT_W | Valid gyroscope samples in this read |
| cnt_tot | output | CNT_W | Packets decoded in this read |

## Verification
A wrong byte index or a wrong stored packet length moves the strobe off its cycle by one or more bytes. It also shifts every decoded word, so the fault shows on the first packet after it arises. A wrong budget value appears as a `rd_done` that comes early or late, and a wrong sequencer state appears as `busy` or the strobe in a cycle where the reference has none. The reference model is compared on every cycle, so any of these faults is caught within one packet time.

// File: rtl/imu_pkt_pkg.sv
// Shared constants and types for the sensor FIFO packet parser.
// Assumes the fixed packet format: one header byte, 16-bit little-endian
// words, dual-sensor packets of 16 bytes and single-sensor packets of 8.
package imu_pkt_pkg;

    localparam int PKT_MAX_BYTES    = 16;
    localparam int PKT_DUAL_BYTES   = 16;
    localparam int PKT_SINGLE_BYTES = 8;
    localparam int IDX_W            = $clog2(PKT_MAX_BYTES);
    localparam int WORD_W           = 16;

    // Header bit positions (the stream format fixes these)
    localparam int HB_EXT     = 7;
    localparam int HB_ACC     = 6;
    localparam int HB_GYR     = 5;
    localparam int HB_ODR_ACC = 1;
    localparam int HB_ODR_GYR = 0;

    localparam logic [WORD_W-1:0] SAMPLE_BAD = 16'h8000;

    typedef enum logic [1:0] {
        HK_STOP,
        HK_SINGLE,
        HK_DUAL
    } hdr_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_HDR,
        PS_BODY
    } parse_state_e;

    typedef struct packed {
        logic              acc;
        logic              gyr;
        logic [WORD_W-1:0] ax;
        logic [WORD_W-1:0] ay;
        logic [WORD_W-1:0] az;
        logic [WORD_W-1:0] gx;
        logic [WORD_W-1:0] gy;
        logic [WORD_W-1:0] gz;
        logic [7:0]        temp;
        logic              ts_vld;
        logic [WORD_W-1:0] ts;
        logic              odr_acc;
        logic              odr_gyr;
    } pkt_fields_t;

endpackage

// File: rtl/imu_hdr_classify.sv
// Header classifier: turns a header byte into a packet kind and the index
// of the packet's final byte. Purely combinational.
// Assumes: extended headers and headers naming no sensor are not decodable.
module imu_hdr_classify
    import imu_pkt_pkg::*;
(
    input  logic [7:0]       hdr,
    output hdr_kind_e        kind,
    output logic [IDX_W-1:0] last_idx
);

    logic unused_low_bits;
    assign unused_low_bits = ^hdr[4:0];

    // Decide packet kind from the extension and sensor-presence bits
    always_comb begin
        if (hdr[HB_EXT] || !(hdr[HB_ACC] || hdr[HB_GYR])) begin
            kind = HK_STOP;
        end else if (hdr[HB_ACC] && hdr[HB_GYR]) begin
            kind = HK_DUAL;
        end else begin
            kind = HK_SINGLE;
        end
    end

    // Final byte index follows from the two sensor bits alone
    always_comb begin
        if (hdr[HB_ACC] && hdr[HB_GYR]) begin
            last_idx = IDX_W'(PKT_DUAL_BYTES - 1);
        end else begin
            last_idx = IDX_W'(PKT_SINGLE_BYTES - 1);
        end
    end

endmodule

// File: rtl/imu_pkt_assemble.sv
// Packet byte store: one register per byte position, written by index.
// The merged view shows the stored bytes with the byte being written this
// cycle already in place, so a packet can be decoded on its final byte.
// Assumes: the writer never uses an index beyond NBYTES-1.
module imu_pkt_assemble #(
    parameter int NBYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NBYTES)-1:0] wr_idx,
    input  logic [7:0]                wr_byte,
    output logic [NBYTES*8-1:0]       merged
);

    localparam int IW = $clog2(NBYTES);

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        logic       hit;
        logic [7:0] held;

        assign hit = wr_en && (wr_idx == IW'(g));

        // Capture the stream byte addressed to this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held <= 8'h00;
            end else if (hit) begin
                held <= wr_byte;
            end
        end

        assign merged[g*8 +: 8] = hit ? wr_byte : held;
    end

endmodule

// File: rtl/imu_pkt_extract.sv
// Field extractor: maps the merged packet bytes onto sample words,
// temperature, timestamp and flags. Purely combinational.
// Assumes byte 0 is the header of a decodable packet; fields of an
// absent sensor and an absent timestamp read as zero.
module imu_pkt_extract
    import imu_pkt_pkg::*;
(
    input  logic [PKT_MAX_BYTES*8-1:0] merged,
    output pkt_fields_t                fields
);

    logic [7:0] b [PKT_MAX_BYTES];
    logic       unused_hdr;

    // Split the flat vector into bytes
    always_comb begin
        for (int i = 0; i < PKT_MAX_BYTES; i++) begin
            b[i] = merged[i*8 +: 8];
        end
    end

    assign unused_hdr = ^{b[0][HB_EXT], b[0][4:2]};

    // Place payload bytes into fields according to the sensor bits
    always_comb begin
        fields         = '0;
        fields.acc     = b[0][HB_ACC];
        fields.gyr     = b[0][HB_GYR];
        fields.odr_acc = b[0][HB_ODR_ACC];
        fields.odr_gyr = b[0][HB_ODR_GYR];
        if (b[0][HB_ACC] && b[0][HB_GYR]) begin
            fields.ax     = {b[2],  b[1]};
            fields.ay     = {b[4],  b[3]};
            fields.az     = {b[6],  b[5]};
            fields.gx     = {b[8],  b[7]};
            fields.gy     = {b[10], b[9]};
            fields.gz     = {b[12], b[11]};
            fields.temp   = b[13];
            fields.ts     = {b[15], b[14]};
            fields.ts_vld = 1'b1;
        end else if (b[0][HB_ACC]) begin
            fields.ax   = {b[2], b[1]};
            fields.ay   = {b[4], b[3]};
            fields.az   = {b[6], b[5]};
            fields.temp = b[7];
        end else if (b[0][HB_GYR]) begin
            fields.gx   = {b[2], b[1]};
            fields.gy   = {b[4], b[3]};
            fields.gz   = {b[6], b[5]};
            fields.temp = b[7];
        end
    end

endmodule

// File: rtl/imu_read_counters.sv
// Per-read counters: total packets and valid samples for each sensor.
// Cleared at the start of a read, advanced once per decoded packet.
// Assumes clr and bump are never high together (the caller gives clr priority).
module imu_read_counters #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bump,
    input  logic         acc_ok,
    input  logic         gyr_ok,
    output logic [W-1:0] cnt_acc,
    output logic [W-1:0] cnt_gyr,
    output logic [W-1:0] cnt_tot
);

    // Clear on a new read, count on each packet
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_acc <= '0;
            cnt_gyr <= '0;
            cnt_tot <= '0;
        end else if (bump) begin
            cnt_tot <= cnt_tot + W'(1);
            if (acc_ok) begin
                cnt_acc <= cnt_acc + W'(1);
            end
            if (gyr_ok) begin
                cnt_gyr <= cnt_gyr + W'(1);
            end
        end
    end

endmodule

// File: rtl/imu_stream_parser.sv
// Top of the FIFO packet parser. A sequencer walks header and body bytes,
// the byte store collects one packet, and the extractor decodes it on its
// final byte into registered outputs with a one-cycle strobe.
// Assumes one byte per in_vld cycle and that the stream starts on a header.
module imu_stream_parser
    import imu_pkt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic [CNT_W-1:0] rd_pkt_count,
    input  logic [CNT_W-1:0] rd_pkt_limit,
    input  logic             in_vld,
    input  logic [7:0]       in_byte,
    output logic             busy,
    output logic             rd_done,
    output logic             pkt_vld,
    output logic             pkt_acc,
    output logic             pkt_gyr,
    output logic [15:0]      acc_x,
    output logic [15:0]      acc_y,
    output logic [15:0]      acc_z,
    output logic [15:0]      gyr_x,
    output logic [15:0]      gyr_y,
    output logic [15:0]      gyr_z,
    output logic [7:0]       pkt_temp,
    output logic             pkt_ts_vld,
    output logic [15:0]      pkt_ts,
    output logic             pkt_odr_acc,
    output logic             pkt_odr_gyr,
    output logic [CNT_W-1:0] cnt_acc,
    output logic [CNT_W-1:0] cnt_gyr,
    output logic [CNT_W-1:0] cnt_tot
);

    parse_state_e               state;
    logic [IDX_W-1:0]           idx;
    logic [IDX_W-1:0]           last_q;
    logic [CNT_W-1:0]           rem;
    logic                       done_q;
    logic                       pvld_q;
    pkt_fields_t                pkt_q;

    hdr_kind_e                  kind;
    logic [IDX_W-1:0]           last_idx;
    logic [PKT_MAX_BYTES*8-1:0] merged;
    pkt_fields_t                fields;
    logic [CNT_W-1:0]           budget;
    logic                       take_hdr;
    logic                       take_body;
    logic                       wr_en;
    logic [IDX_W-1:0]           wr_idx;
    logic                       emit;
    logic                       acc_ok;
    logic                       gyr_ok;

    imu_hdr_classify u_hdr (
        .hdr      (in_byte),
        .kind     (kind),
        .last_idx (last_idx)
    );

    imu_pkt_assemble #(.NBYTES(PKT_MAX_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (in_byte),
        .merged  (merged)
    );

    imu_pkt_extract u_extract (
        .merged (merged),
        .fields (fields)
    );

    imu_read_counters #(.W(CNT_W)) u_counts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rd_start),
        .bump    (emit),
        .acc_ok  (acc_ok),
        .gyr_ok  (gyr_ok),
        .cnt_acc (cnt_acc),
        .cnt_gyr (cnt_gyr),
        .cnt_tot (cnt_tot)
    );

    // Effective packet budget for a new read
    always_comb begin
        if ((rd_pkt_limit != '0) && (rd_pkt_limit < rd_pkt_count)) begin
            budget = rd_pkt_limit;
        end else begin
            budget = rd_pkt_count;
        end
    end

    // Byte acceptance, store addressing and packet-completion decode
    always_comb begin
        take_hdr  = !rd_start && in_vld && (state == PS_HDR);
        take_body = !rd_start && in_vld && (state == PS_BODY);
        wr_en     = (take_hdr && (kind != HK_STOP)) || take_body;
        wr_idx    = (state == PS_HDR) ? '0 : idx;
        emit      = take_body && (idx == last_q);
        acc_ok    = fields.acc && (fields.ax != SAMPLE_BAD);
        gyr_ok    = fields.gyr && (fields.gx != SAMPLE_BAD);
    end

    // Read sequencer: budget, byte index, packet length, end of read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            idx    <= '0;
            last_q <= '0;
            rem    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rd_start) begin
                rem    <= budget;
                idx    <= '0;
                state  <= (budget == '0) ? PS_IDLE : PS_HDR;
                done_q <= (budget == '0);
            end else if (take_hdr) begin
                if (kind == HK_STOP) begin
                    state  <= PS_IDLE;
                    done_q <= 1'b1;
                end else begin
                    idx    <= IDX_W'(1);
                    last_q <= last_idx;
                    state  <= PS_BODY;
                end
            end else if (take_body) begin
                if (emit) begin
                    rem <= rem - CNT_W'(1);
                    idx <= '0;
                    if (rem == CNT_W'(1)) begin
                        state  <= PS_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= PS_HDR;
                    end
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // Output register for decoded packets and the packet strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvld_q <= 1'b0;
            pkt_q  <= '0;
        end else begin
            pvld_q <= emit;
            if (emit) begin
                pkt_q <= fields;
            end
        end
    end

    assign busy        = (state != PS_IDLE);
    assign rd_done     = done_q;
    assign pkt_vld     = pvld_q;
    assign pkt_acc     = pkt_q.acc;
    assign pkt_gyr     = pkt_q.gyr;
    assign acc_x       = pkt_q.ax;
    assign acc_y       = pkt_q.ay;
    assign acc_z       = pkt_q.az;
    assign gyr_x       = pkt_q.gx;
    assign gyr_y       = pkt_q.gy;
    assign gyr_z       = pkt_q.gz;
    assign pkt_temp    = pkt_q.temp;
    assign pkt_ts_vld  = pkt_q.ts_vld;
    assign pkt_ts      = pkt_q.ts;
    assign pkt_odr_acc = pvld_q && pkt_q.odr_acc;
    assign pkt_odr_gyr = pvld_q && pkt_q.odr_gyr;

endmodule

// File: rtl/imu_stream_parser_chk.sv
// Property checker for the packet parser, attached through bind.
// Observes ports only.
module imu_stream_parser_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_start,
    input logic             busy,
    input logic             rd_done,
    input logic             pkt_vld,
    input logic             pkt_acc,
    input logic             pkt_gyr,
    input logic             pkt_ts_vld,
    input logic [CNT_W-1:0] cnt_acc,
    input logic [CNT_W-1:0] cnt_gyr,
    input logic [CNT_W-1:0] cnt_tot
);

    AST_START_REACTS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (busy ^ rd_done)); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !busy); // R10

    AST_PKT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld |-> $past(busy)); // R10

    AST_PKT_HAS_SENSOR: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld |-> (pkt_acc || pkt_gyr)); // R7

    AST_TS_ONLY_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld |-> (pkt_ts_vld == (pkt_acc && pkt_gyr))); // R5

    AST_TOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld |-> (cnt_tot == $past(cnt_tot) + CNT_W'(1))); // R9

    AST_SENSOR_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_acc <= cnt_tot) && (cnt_gyr <= cnt_tot)); // R9

    AST_TOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_vld && !$past(rd_start)) |-> $stable(cnt_tot)); // R11

endmodule

bind imu_stream_parser imu_stream_parser_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start   (rd_start),
    .busy       (busy),
    .rd_done    (rd_done),
    .pkt_vld    (pkt_vld),
    .pkt_acc    (pkt_acc),
    .pkt_gyr    (pkt_gyr),
    .pkt_ts_vld (pkt_ts_vld),
    .cnt_acc    (cnt_acc),
    .cnt_gyr    (cnt_gyr),
    .cnt_tot    (cnt_tot)
);

// File: tb/imu_stream_parser_test.sv
// Bench: a behavioural reference model (byte queue, integer counters),
// compared with the design on every falling edge, plus directed checks.
module imu_stream_parser_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_start;
    logic [CW-1:0] rd_pkt_count;
    logic [CW-1:0] rd_pkt_limit;
    logic          in_vld;
    logic [7:0]    in_byte;
    logic          busy, rd_done, pkt_vld, pkt_acc, pkt_gyr;
    logic [15:0]   acc_x, acc_y, acc_z, gyr_x, gyr_y, gyr_z, pkt_ts;
    logic [7:0]    pkt_temp;
    logic          pkt_ts_vld, pkt_odr_acc, pkt_odr_gyr;
    logic [CW-1:0] cnt_acc, cnt_gyr, cnt_tot;

    always #4 clk = ~clk;

    imu_stream_parser #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
        .rd_pkt_count(rd_pkt_count), .rd_pkt_limit(rd_pkt_limit),
        .in_vld(in_vld), .in_byte(in_byte), .busy(busy), .rd_done(rd_done),
        .pkt_vld(pkt_vld), .pkt_acc(pkt_acc), .pkt_gyr(pkt_gyr),
        .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .gyr_x(gyr_x), .gyr_y(gyr_y), .gyr_z(gyr_z),
        .pkt_temp(pkt_temp), .pkt_ts_vld(pkt_ts_vld), .pkt_ts(pkt_ts),
        .pkt_odr_acc(pkt_odr_acc), .pkt_odr_gyr(pkt_odr_gyr),
        .cnt_acc(cnt_acc), .cnt_gyr(cnt_gyr), .cnt_tot(cnt_tot)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state
    logic        m_busy = 0, m_done = 0, m_pv = 0, m_acc = 0, m_gyr = 0;
    logic        m_tsv = 0, m_oa = 0, m_og = 0;
    logic [15:0] m_ax = 0, m_ay = 0, m_az = 0, m_gx = 0, m_gy = 0, m_gz = 0, m_ts = 0;
    logic [7:0]  m_temp = 0;
    logic [7:0]  m_hdr;
    int          m_ca = 0, m_cg = 0, m_ct = 0, m_rem = 0, m_tgt, m_need;
    logic [7:0]  q[$];

    function automatic logic [15:0] qw(int i);
        return {q[i+1], q[i]};
    endfunction

    // Reference model: advances on every rising edge from the port inputs
    always @(posedge clk) begin
        m_done = 0; m_pv = 0; m_oa = 0; m_og = 0;
        if (!rst_n) begin
            m_busy = 0; m_acc = 0; m_gyr = 0; m_tsv = 0;
            m_ax = 0; m_ay = 0; m_az = 0; m_gx = 0; m_gy = 0; m_gz = 0;
            m_ts = 0; m_temp = 0; m_ca = 0; m_cg = 0; m_ct = 0; m_rem = 0;
            q.delete();
        end else if (rd_start) begin
            m_tgt = (rd_pkt_limit != 0 && rd_pkt_limit < rd_pkt_count)
                    ? int'(rd_pkt_limit) : int'(rd_pkt_count);
            m_ca = 0; m_cg = 0; m_ct = 0; q.delete();
            m_rem = m_tgt;
            m_busy = (m_tgt != 0);
            m_done = (m_tgt == 0);
        end else if (m_busy && in_vld) begin
            q.push_back(in_byte);
            m_hdr = q[0];
            m_need = (m_hdr[6] && m_hdr[5]) ? 16 : 8;
            if (q.size() == 1 && (m_hdr[7] || !(m_hdr[6] || m_hdr[5]))) begin
                m_busy = 0; m_done = 1; q.delete();
            end else if (q.size() == m_need) begin
                m_pv = 1; m_acc = m_hdr[6]; m_gyr = m_hdr[5];
                m_oa = m_hdr[1]; m_og = m_hdr[0];
                m_ax = 0; m_ay = 0; m_az = 0; m_gx = 0; m_gy = 0; m_gz = 0;
                m_ts = 0; m_tsv = 0;
                if (m_acc && m_gyr) begin
                    m_ax = qw(1); m_ay = qw(3); m_az = qw(5);
                    m_gx = qw(7); m_gy = qw(9); m_gz = qw(11);
                    m_temp = q[13]; m_ts = qw(14); m_tsv = 1;
                end else if (m_acc) begin
                    m_ax = qw(1); m_ay = qw(3); m_az = qw(5); m_temp = q[7];
                end else begin
                    m_gx = qw(1); m_gy = qw(3); m_gz = qw(5); m_temp = q[7];
                end
                m_ct++;
                if (m_acc && m_ax != 16'h8000) m_ca++;
                if (m_gyr && m_gx != 16'h8000) m_cg++;
                m_rem--;
                q.delete();
                if (m_rem == 0) begin m_busy = 0; m_done = 1; end
            end
        end
    end

    task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, nm, act, exp);
        end
    endtask

    task automatic check(string req, string nm, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %0h expected %0h", req, nm, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, plus the watchdog
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            vectors++;
            cmp("busy",    32'(busy),        32'(m_busy));
            cmp("done",    32'(rd_done),     32'(m_done));
            cmp("pkt_vld", 32'(pkt_vld),     32'(m_pv));
            cmp("acc",     32'(pkt_acc),     32'(m_acc));
            cmp("gyr",     32'(pkt_gyr),     32'(m_gyr));
            cmp("acc_x",   32'(acc_x),       32'(m_ax));
            cmp("acc_y",   32'(acc_y),       32'(m_ay));
            cmp("acc_z",   32'(acc_z),       32'(m_az));
            cmp("gyr_x",   32'(gyr_x),       32'(m_gx));
            cmp("gyr_y",   32'(gyr_y),       32'(m_gy));
            cmp("gyr_z",   32'(gyr_z),       32'(m_gz));
            cmp("temp",    32'(pkt_temp),    32'(m_temp));
            cmp("ts_vld",  32'(pkt_ts_vld),  32'(m_tsv));
            cmp("ts",      32'(pkt_ts),      32'(m_ts));
            cmp("odr_acc", 32'(pkt_odr_acc), 32'(m_oa));
            cmp("odr_gyr", 32'(pkt_odr_gyr), 32'(m_og));
            cmp("cnt_acc", 32'(cnt_acc),     32'(m_ca));
            cmp("cnt_gyr", 32'(cnt_gyr),     32'(m_cg));
            cmp("cnt_tot", 32'(cnt_tot),     32'(m_ct));
        end
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL R10 watchdog actual %0d expected %0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic start_read(int cnt, int lim);
        @(negedge clk);
        rd_start = 1; rd_pkt_count = CW'(cnt); rd_pkt_limit = CW'(lim); in_vld = 0;
        @(negedge clk);
        rd_start = 0;
    endtask

    task automatic send_byte(logic [7:0] b, bit gap);
        if (gap) begin
            @(negedge clk);
            in_vld = 0;
        end
        @(negedge clk);
        in_vld = 1; in_byte = b;
    endtask

    task automatic send_word(logic [15:0] w, bit gap);
        send_byte(w[7:0], gap);
        send_byte(w[15:8], gap);
    endtask

    task automatic send_dual(logic [7:0] h, logic [15:0] ax, ay, az, gx, gy, gz,
                             logic [7:0] t, logic [15:0] ts);
        send_byte(h, 0);
        send_word(ax, 0); send_word(ay, 0); send_word(az, 0);
        send_word(gx, 0); send_word(gy, 0); send_word(gz, 0);
        send_byte(t, 0);
        send_word(ts, 0);
    endtask

    task automatic send_single(logic [7:0] h, logic [15:0] x, y, z, logic [7:0] t, bit gap);
        send_byte(h, gap);
        send_word(x, gap); send_word(y, gap); send_word(z, gap);
        send_byte(t, gap);
    endtask

    task automatic step_idle();
        @(negedge clk);
        in_vld = 0;
    endtask

    task automatic finish_read(string req);
        step_idle();
        for (int i = 0; i < 64; i++) begin
            if (rd_done) break;
            @(negedge clk);
        end
        check(req, "rd_done", 32'(rd_done), 32'd1);
    endtask

    initial begin
        rst_n = 0; rd_start = 0; rd_pkt_count = 0; rd_pkt_limit = 0;
        in_vld = 0; in_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy",    32'(busy),    0);
        check("R1", "done",    32'(rd_done), 0);
        check("R1", "pkt_vld", 32'(pkt_vld), 0);
        check("R1", "cnt_tot", 32'(cnt_tot), 0);
        check("R1", "odr",     32'({pkt_odr_acc, pkt_odr_gyr}), 0);

        // R4 / R5 / R8 / R9 / R11: three packets of mixed kinds
        cur_req = "R4";
        start_read(3, 0);
        send_dual(8'h63, 16'h1234, 16'hFFFE, 16'h7FFF, 16'h8001, 16'h0010,
                  16'hABCD, 8'hE5, 16'hBEEF);
        step_idle();
        check("R4", "pkt_vld", 32'(pkt_vld), 1);
        check("R4", "acc_x",   32'(acc_x), 32'h1234);
        check("R4", "gyr_z",   32'(gyr_z), 32'hABCD);
        check("R4", "ts",      32'({pkt_ts_vld, pkt_ts}), 32'h1BEEF);
        check("R8", "odr",     32'({pkt_odr_acc, pkt_odr_gyr}), 32'h3);
        @(negedge clk);
        check("R8", "odr off", 32'({pkt_odr_acc, pkt_odr_gyr}), 0);
        cur_req = "R11";
        send_single(8'h5C, 16'h0042, 16'h0102, 16'hF00D, 8'h11, 1);
        step_idle();
        check("R5", "acc/gyr", 32'({pkt_acc, pkt_gyr}), 32'h2);
        check("R5", "ts_vld",  32'(pkt_ts_vld), 0);
        check("R5", "gyr_x",   32'(gyr_x), 0);
        check("R11", "temp",   32'(pkt_temp), 32'h11);
        check("R11", "acc_z",  32'(acc_z), 32'hF00D);
        cur_req = "R9";
        send_single(8'h22, 16'h8000, 16'h0005, 16'h0006, 8'h80, 0);
        finish_read("R10");
        check("R9", "cnt_tot", 32'(cnt_tot), 3);
        check("R9", "cnt_acc", 32'(cnt_acc), 2);
        check("R9", "cnt_gyr", 32'(cnt_gyr), 1);
        check("R8", "odr",     32'({pkt_odr_acc, pkt_odr_gyr}), 32'h2);
        check("R10", "busy",   32'(busy), 0);

        // R2 / R10: limit caps the read, later bytes ignored
        cur_req = "R2";
        start_read(5, 2);
        check("R2", "busy",    32'(busy), 1);
        check("R2", "cnt_tot", 32'(cnt_tot), 0);
        send_single(8'h40, 16'h0001, 16'h0002, 16'h0003, 8'h04, 0);
        send_single(8'h40, 16'h0011, 16'h0012, 16'h0013, 8'h14, 0);
        finish_read("R10");
        check("R2", "cnt_tot", 32'(cnt_tot), 2);
        cur_req = "R10";
        send_single(8'h40, 16'h0021, 16'h0022, 16'h0023, 8'h24, 0);
        step_idle();
        step_idle();
        check("R10", "cnt_tot", 32'(cnt_tot), 2);
        check("R10", "acc_x",   32'(acc_x), 32'h0011);

        // R3: zero budget
        cur_req = "R3";
        start_read(0, 0);
        check("R3", "rd_done", 32'(rd_done), 1);
        check("R3", "busy",    32'(busy), 0);
        check("R3", "cnt_tot", 32'(cnt_tot), 0);

        // R6: extended header stops the read
        cur_req = "R6";
        start_read(4, 0);
        send_single(8'h20, 16'h0100, 16'h0200, 16'h0300, 8'h7F, 0);
        send_byte(8'hE0, 0);
        finish_read("R6");
        check("R6", "cnt_tot", 32'(cnt_tot), 1);
        check("R6", "cnt_gyr", 32'(cnt_gyr), 1);
        send_dual(8'h60, 1, 2, 3, 4, 5, 6, 8'h07, 16'h0809);
        step_idle();
        check("R6", "pkt_vld", 32'(pkt_vld), 0);
        check("R6", "cnt_tot", 32'(cnt_tot), 1);

        // R7: header naming no sensor stops the read
        cur_req = "R7";
        start_read(4, 0);
        send_byte(8'h1F, 0);
        finish_read("R7");
        check("R7", "cnt_tot", 32'(cnt_tot), 0);
        check("R7", "busy",    32'(busy), 0);

        // R12: restart in the middle of a packet
        cur_req = "R12";
        start_read(2, 0);
        for (int i = 0; i < 5; i++) send_byte((i == 0) ? 8'h60 : 8'h33, 0);
        start_read(1, 0);
        check("R12", "busy", 32'(busy), 1);
        send_single(8'h40, 16'h0A0B, 16'h0C0D, 16'h0E0F, 8'h01, 0);
        finish_read("R12");
        check("R12", "cnt_tot", 32'(cnt_tot), 1);
        check("R12", "acc_x",   32'(acc_x), 32'h0A0B);

        // R2: limit above count leaves the count in force
        cur_req = "R2";
        start_read(1, 9);
        send_single(8'h21, 16'h0007, 16'h0008, 16'h0009, 8'h02, 0);
        finish_read("R2");
        check("R2", "cnt_gyr", 32'(cnt_gyr), 1);

        repeat (3) step_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule